// File: doc/BRIEF.md
# Wiper Position Counter and Tap Decoder

This block keeps the position of a digitally controlled potentiometer wiper in a 6-bit register and turns it into a one-hot enable for 64 tap switches along the resistor chain. The wiper position can change in four ways. A host can write a value directly. A value can be copied from one of four stored settings. The position can move one step up or down per request. After every reset it reloads stored setting zero. Position 0 drives the switch at the low end of the chain, and the highest position drives the switch at the high end.

A serial front end feeds the block with decoded requests. The stored settings come in on a flat bus, one 6-bit slot per setting, so the block never keeps its own copy of them. When more than one request arrives in the same cycle, a fixed priority decides which one acts. Every step request is clamped at the ends of the range. The current position is also given as a byte padded with zeros, ready to be shifted out most significant bit first.

Top module: `wiper_ctr_top`

## Requirements
- R1: `tap_en` always has exactly one bit set, and that bit is bit number `pos`.
- R2: `pos` = 0 sets only `tap_en[0]` (low end of the chain). `pos` = 63 sets only `tap_en[63]` (high end).
- R3: In every cycle after a clock edge with `rst_n` low, `pos` is 0 and `tap_en` is 1.
- R4: At the first clock edge with `rst_n` high after reset, `pos` loads setting 0 (`dr_bank[5:0]`). All requests presented in that cycle are ignored.
- R5: `ser_load` high at an edge makes `pos` equal `ser_val` after that edge.
- R6: `par_load` high makes `pos` equal setting `par_sel`, which is `dr_bank[6*par_sel+5 : 6*par_sel]`.
- R7: `step_en` high moves `pos` by +1 when `step_up` = 1 and by −1 when `step_up` = 0.
- R8: A step up at 63 leaves `pos` at 63. A step down at 0 leaves `pos` at 0. Neither wraps.
- R9: Priority is reset reload first, then `ser_load`, then `par_load`, then `step_en`. A request that loses has no effect.
- R10: `rd_byte` equals {2'b00, `pos`}.
- R11: With no request, `pos` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dr_bank | input | 24 | Four stored settings; setting i is at bits [6i+5:6i] |
| ser_load | input | 1 | Load `ser_val` directly |
| ser_val | input | 6 | Value written directly by the host |
| par_load | input | 1 | Load from the stored setting chosen by `par_sel` |
| par_sel | input | 2 | Index of the stored setting |
| step_en | input | 1 | One-step move request |
| step_up | input | 1 | Step direction: 1 = toward the high end, 0 = toward the low end |
| pos | output | 6 | Current wiper position |
| tap_en | output | 64 | One-hot enables for the tap switches |
| rd_byte | output | 8 | Readback byte {2'b00, pos} |

## Verification
The cases that collide are a load and a step request in the same cycle, and the reset reload meeting any host request in its first cycle. The bench raises `ser_load`, `par_load` and `step_en` together and in pairs. It also holds all three high on the cycle `rst_n` is released. It then checks that only the winning source decides the next position. Random cycles set each request line on its own probability, so overlaps happen often. A step at either end of the range is produced on purpose, to show that the saturating counter is only overridden by a load.

// File: rtl/wiper_pkg.sv
// Shared types for the wiper counter.
// It assumes the users take the source names from here and nothing else.
package wiper_pkg;
    // Selects which source writes the position register in the current cycle.
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INIT = 3'd1,
        SRC_SER  = 3'd2,
        SRC_PAR  = 3'd3,
        SRC_INC  = 3'd4,
        SRC_DEC  = 3'd5
    } wiper_src_e;
endpackage

// File: rtl/wiper_arb.sv
// Fixed-priority choice among the requests that update the position.
// Order: reset reload, direct write, copy from a stored setting, step.
// It assumes each request is a level that is sampled once per clock.
module wiper_arb
    import wiper_pkg::*;
(
    input  logic       init_pend,
    input  logic       ser_load,
    input  logic       par_load,
    input  logic       step_en,
    input  logic       step_up,
    output wiper_src_e src
);
    // Picks the winning source for this cycle.
    always_comb begin
        if (init_pend)     src = SRC_INIT;
        else if (ser_load) src = SRC_SER;
        else if (par_load) src = SRC_PAR;
        else if (step_en)  src = step_up ? SRC_INC : SRC_DEC;
        else               src = SRC_HOLD;
    end
endmodule

// File: rtl/wiper_next.sv
// Works out the next position from the chosen source.
// A step stops at either end of the range and does not wrap.
// It assumes dr_bank packs setting i at bits [i*POS_W +: POS_W].
module wiper_next
    import wiper_pkg::*;
#(
    parameter int POS_W  = 6,
    parameter int NUM_DR = 4,
    localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
    input  wiper_src_e                src,
    input  logic [POS_W-1:0]          cur,
    input  logic [NUM_DR*POS_W-1:0]   dr_bank,
    input  logic [POS_W-1:0]          ser_val,
    input  logic [SEL_W-1:0]          par_sel,
    output logic [POS_W-1:0]          nxt
);
    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    logic [POS_W-1:0] par_val;

    // Takes the selected stored setting out of the flat bank.
    always_comb par_val = dr_bank[par_sel*POS_W +: POS_W];

    // Builds the next value; a step clamps at either end.
    always_comb begin
        unique case (src)
            SRC_INIT: nxt = dr_bank[POS_W-1:0];
            SRC_SER:  nxt = ser_val;
            SRC_PAR:  nxt = par_val;
            SRC_INC:  nxt = (cur == TOP)       ? cur : cur + 1'b1;
            SRC_DEC:  nxt = (cur == '0)        ? cur : cur - 1'b1;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/wiper_decode.sv
// Turns the position into one-hot tap enables: bit i is set when pos == i.
// It assumes 2**POS_W taps, so every position value has its own tap.
module wiper_decode #(
    parameter int  POS_W = 6,
    localparam int TAPS  = 1 << POS_W
) (
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  tap_en
);
    // One compare per tap; only one position value can match.
    for (genvar gi = 0; gi < TAPS; gi++) begin : g_tap
        assign tap_en[gi] = (pos == POS_W'(gi));
    end
endmodule

// File: rtl/wiper_ctr_top.sv
// Wiper position register with reload after reset, direct and copy loads,
// clamped steps, a one-hot tap decode and a zero-padded readback byte.
// It assumes rst_n is synchronous. While it is low the position is 0;
// setting 0 is reloaded at the first edge after rst_n goes high.
module wiper_ctr_top #(
    parameter int  POS_W  = 6,
    parameter int  NUM_DR = 4,
    localparam int TAPS   = 1 << POS_W,
    localparam int SEL_W  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DR*POS_W-1:0]   dr_bank,
    input  logic                      ser_load,
    input  logic [POS_W-1:0]          ser_val,
    input  logic                      par_load,
    input  logic [SEL_W-1:0]          par_sel,
    input  logic                      step_en,
    input  logic                      step_up,
    output logic [POS_W-1:0]          pos,
    output logic [TAPS-1:0]           tap_en,
    output logic [POS_W+1:0]          rd_byte
);
    import wiper_pkg::*;

    logic             init_pend;
    wiper_src_e       src;
    logic [POS_W-1:0] nxt;

    wiper_arb u_arb (
        .init_pend (init_pend),
        .ser_load  (ser_load),
        .par_load  (par_load),
        .step_en   (step_en),
        .step_up   (step_up),
        .src       (src)
    );

    wiper_next #(.POS_W(POS_W), .NUM_DR(NUM_DR)) u_next (
        .src     (src),
        .cur     (pos),
        .dr_bank (dr_bank),
        .ser_val (ser_val),
        .par_sel (par_sel),
        .nxt     (nxt)
    );

    // Position register plus the flag that marks the reload still to come.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos       <= '0;
            init_pend <= 1'b1;
        end else begin
            pos       <= nxt;
            init_pend <= 1'b0;
        end
    end

    wiper_decode #(.POS_W(POS_W)) u_dec (
        .pos    (pos),
        .tap_en (tap_en)
    );

    // Readback byte: two zero bits, then the position.
    always_comb rd_byte = {2'b00, pos};
endmodule

// File: rtl/wiper_ctr_chk.sv
// Property checker for wiper_ctr_top, attached with bind below.
// It assumes rst_n is synchronous and that the top module's port names are used.
module wiper_ctr_chk #(
    parameter int  POS_W  = 6,
    parameter int  NUM_DR = 4,
    localparam int TAPS   = 1 << POS_W,
    localparam int SEL_W  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_DR*POS_W-1:0] dr_bank,
    input logic                    ser_load,
    input logic [POS_W-1:0]        ser_val,
    input logic                    par_load,
    input logic [SEL_W-1:0]        par_sel,
    input logic                    step_en,
    input logic                    step_up,
    input logic [POS_W-1:0]        pos,
    input logic [TAPS-1:0]         tap_en,
    input logic [POS_W+1:0]        rd_byte
);
    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    logic [POS_W-1:0] pick;
    // Setting chosen by par_sel, taken straight from the bank.
    always_comb pick = dr_bank[par_sel*POS_W +: POS_W];

    // R1
    one_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_en) == 1) && tap_en[pos]);

    // R3
    reset_tap0_chk: assert property (@(posedge clk)
        !rst_n |=> (pos == '0) && (tap_en == TAPS'(1)));

    // R4
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> pos == $past(dr_bank[POS_W-1:0]));

    // R5
    ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ser_load |=> pos == $past(ser_val));

    // R6
    par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && par_load && !ser_load |=> pos == $past(pick));

    // R8
    top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && step_en && step_up && !ser_load && !par_load
        && pos == TOP |=> pos == TOP);

    // R8
    bot_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && step_en && !step_up && !ser_load && !par_load
        && pos == '0 |=> pos == '0);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !step_en && !ser_load && !par_load |=> $stable(pos));

    // R10
    rd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte == {2'b00, pos});
endmodule

bind wiper_ctr_top wiper_ctr_chk #(.POS_W(POS_W), .NUM_DR(NUM_DR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dr_bank  (dr_bank),
    .ser_load (ser_load),
    .ser_val  (ser_val),
    .par_load (par_load),
    .par_sel  (par_sel),
    .step_en  (step_en),
    .step_up  (step_up),
    .pos      (pos),
    .tap_en   (tap_en),
    .rd_byte  (rd_byte)
);

// File: tb/test_wiper_ctr_top.sv
// Self-checking bench: directed corner cases, then seeded random cycles,
// compared with a reference model written as a bench function.
module test_wiper_ctr_top;
    localparam int POS_W = 6;
    localparam int NUM_DR = 4;
    localparam int TAPS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] dr_bank = '0;
    logic        ser_load = 1'b0;
    logic [5:0]  ser_val = '0;
    logic        par_load = 1'b0;
    logic [1:0]  par_sel = '0;
    logic        step_en = 1'b0;
    logic        step_up = 1'b0;
    logic [5:0]  pos;
    logic [63:0] tap_en;
    logic [7:0]  rd_byte;

    int n_chk = 0;
    int n_bad = 0;
    int exp_pos = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wiper_ctr_top #(.POS_W(POS_W), .NUM_DR(NUM_DR)) i_wiper_ctr_top (
        .clk(clk), .rst_n(rst_n), .dr_bank(dr_bank),
        .ser_load(ser_load), .ser_val(ser_val),
        .par_load(par_load), .par_sel(par_sel),
        .step_en(step_en), .step_up(step_up),
        .pos(pos), .tap_en(tap_en), .rd_byte(rd_byte)
    );

    // Reference next position for the cycle after an edge with rst_n high.
    function automatic int model_next(int cur, bit init, bit sl, int sv,
                                      bit pl, int ps, bit se, bit su,
                                      logic [23:0] bank);
        if (init) return int'(bank[5:0]);
        if (sl) return sv;
        if (pl) return int'(bank[ps*6 +: 6]);
        if (se) begin
            if (su) return (cur == 63) ? 63 : cur + 1;
            return (cur == 0) ? 0 : cur - 1;
        end
        return cur;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Checks every output against the model value; rtag names the case.
    task automatic check_outs(string rtag);
        check({rtag, " R1 tap"}, tap_en, 64'd1 << exp_pos);
        check({rtag, " pos"}, 64'(pos), 64'(exp_pos));
        check("R10 rd_byte", 64'(rd_byte), 64'(exp_pos));
    endtask

    // Drives one cycle at the falling edge, models it, and checks at the next falling edge.
    task automatic cyc(bit init, bit sl, int sv, bit pl, int ps, bit se, bit su,
                       string rtag);
        ser_load = sl; ser_val = 6'(sv); par_load = pl; par_sel = 2'(ps);
        step_en = se; step_up = su;
        exp_pos = model_next(exp_pos, init, sl, sv, pl, ps, se, su, dr_bank);
        @(posedge clk); @(negedge clk);
        check_outs(rtag);
    endtask

    task automatic do_reset(logic [23:0] bank);
        @(negedge clk);
        rst_n = 1'b0; dr_bank = bank;
        ser_load = 1'b1; par_load = 1'b1; step_en = 1'b1; step_up = 1'b1;
        ser_val = 6'h2A;
        @(posedge clk); @(negedge clk);
        exp_pos = 0;
        check_outs("R3 reset");
        check("R2 low end", 64'(tap_en[0]), 64'd1);
        rst_n = 1'b1;
        // R4: every request is high in the reload cycle, and all are ignored.
        cyc(1'b1, 1'b1, 42, 1'b1, 3, 1'b1, 1'b1, "R4 init");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset({6'd50, 6'd33, 6'd17, 6'd9});
        check("R4 setting0", 64'(pos), 64'd9);
        cyc(0, 0, 0, 0, 0, 0, 0, "R11 idle");
        cyc(0, 1, 61, 0, 0, 0, 0, "R5 ser");
        for (int k = 0; k < NUM_DR; k++) cyc(0, 0, 0, 1, k, 0, 0, "R6 par");
        cyc(0, 1, 62, 0, 0, 0, 0, "R5 ser");
        cyc(0, 0, 0, 0, 0, 1, 1, "R7 up");
        cyc(0, 0, 0, 0, 0, 1, 1, "R8 top clamp");
        check("R2 high end", 64'(tap_en[63]), 64'd1);
        cyc(0, 0, 0, 0, 0, 1, 0, "R7 down");
        cyc(0, 1, 0, 0, 0, 0, 0, "R5 ser zero");
        cyc(0, 0, 0, 0, 0, 1, 0, "R8 bottom clamp");
        cyc(0, 1, 20, 1, 2, 1, 1, "R9 ser wins all");
        cyc(0, 0, 0, 1, 1, 1, 0, "R9 par beats step");
        cyc(0, 1, 5, 1, 3, 0, 0, "R9 ser beats par");
        cyc(0, 0, 0, 0, 0, 0, 1, "R11 step_up alone");
        // A second reset with a different setting 0, then random traffic.
        do_reset({6'd1, 6'd2, 6'd3, 6'd63});
        for (int i = 0; i < 3000; i++) begin
            if (i % 50 == 0) dr_bank = 24'($urandom);
            cyc(0, ($urandom % 6) == 0, int'($urandom % 64),
                ($urandom % 5) == 0, int'($urandom % 4),
                ($urandom % 3) != 0, ($urandom % 2) == 0, "R9 random");
        end
        do_reset(24'($urandom));
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule